// File: doc/BRIEF.md
# Color-Tagged In-Order Completion Tracker

This block sits beside an out-of-order transfer engine and tells the user, in the original acceptance order, which transactions have finished. Each accepted input word carries a fixed number of slots. Each slot has a valid bit and user metadata. Every slot of the word is tagged with a 1-bit epoch color from an internal generator and stored in a multi-slot ring FIFO. The slots are held there until the planner confirms that every transfer of that color has landed in the destination.

The generator starts at color 0. It flips once after the very first accepted word. After that it flips only on a confirmation. As a result, the color being assigned always differs from the color the planner is currently working on, except for the very first word. On a confirmation, the block releases exactly the entries of the epoch that was being worked on. Released entries appear at the head of the FIFO as a prefix of the output slots. The user takes them with a per-slot read strobe, which must also form a prefix.

Top module: `cmpl_order_tracker`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is all zeros.
- R2: The first accepted word is tagged color 0. Words accepted after it, up to the first confirmation, are tagged color 1.
- R3: Each confirmation flips the tagging color. Words accepted after a confirmation of color c carry color c, until the next confirmation.
- R4: Every slot of an accepted word is stored, including slots whose valid bit is 0. The stored valid bit is returned on `out_slot_vld` and the metadata on `out_meta`, where slot i occupies bits [i*META_W +: META_W].
- R5: No entry is offered on `out_valid` until a confirmation for its epoch has arrived. While no confirmation arrives, the count of set `out_valid` bits never grows.
- R6: Entries are presented in acceptance order, word by word, with slot 0 of a word before slot 1. An offered head entry keeps its color and metadata until it is read.
- R7: `in_ready` is 0 whenever fewer than SLOTS entries are free. A word offered while `in_ready` is 0 is neither stored nor counted.
- R8: `out_valid` is always a contiguous prefix starting at slot 0. Bit i is set exactly when more than i released entries remain.
- R9: `out_read` must be a prefix of `out_valid`. Slot i of `out_read` may only be set when every lower slot is also set and slot i is offered.
- R10: A confirmation that arrives before any word has been accepted is ignored. A word accepted in the same cycle as a confirmation belongs to the next epoch and is released only by the following confirmation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The FIFO has room for a full word |
| in_slot_vld | input | SLOTS | Per-slot transaction valid bit |
| in_meta | input | SLOTS*META_W | Per-slot user metadata |
| conf_valid | input | 1 | Confirmation pulse from the planner |
| conf_color | input | 1 | Color of the epoch being confirmed |
| out_valid | output | SLOTS | Head slots released for reading (prefix) |
| out_slot_vld | output | SLOTS | Stored valid bit of each head slot |
| out_color | output | SLOTS | Stored color of each head slot |
| out_meta | output | SLOTS*META_W | Stored metadata of each head slot |
| out_read | input | SLOTS | Per-slot read strobe (prefix of out_valid) |

## Verification
Suppose the epoch counters are wrong. Then `out_valid` rises one cycle after the wrong confirmation, either too early, before the matching confirmation, or not at all. The bench looks at that cycle after every confirmation. A fault in the color generator shows up only when the affected entries are released, as a wrong `out_color`, possibly several epochs later. A fault in pointer or fill tracking shows up as shifted metadata at the head, or as `in_ready` at the wrong level when the FIFO is exactly full.

// File: rtl/cmpl_order_tracker.sv
module cmpl_order_tracker #(
  parameter int SLOTS  = 4,
  parameter int META_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SLOTS-1:0]          in_slot_vld,
  input  logic [SLOTS*META_W-1:0]   in_meta,
  input  logic                      conf_valid,
  input  logic                      conf_color,
  output logic [SLOTS-1:0]          out_valid,
  output logic [SLOTS-1:0]          out_slot_vld,
  output logic [SLOTS-1:0]          out_color,
  output logic [SLOTS*META_W-1:0]   out_meta,
  input  logic [SLOTS-1:0]          out_read
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [META_W-1:0] mem_meta [DEPTH];
  logic [DEPTH-1:0]  mem_vld, mem_col;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill, avail, acc, waitc, rd_n;
  logic              gen_color, started;

  wire push     = in_valid && in_ready;
  wire conf_eff = conf_valid && started;
  wire flip     = (push && !started) || conf_eff;
  wire [CW-1:0] push_n = push ? CW'(SLOTS) : '0;

  assign in_ready = (CW'(DEPTH) - fill) >= CW'(SLOTS);

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < SLOTS; i++)
      rd_n = rd_n + CW'(out_read[i]);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_head
    wire [AW-1:0] ridx = rd_ptr + AW'(g);
    assign out_valid[g]                   = CW'(g) < avail;
    assign out_slot_vld[g]                = mem_vld[ridx];
    assign out_color[g]                   = mem_col[ridx];
    assign out_meta[g*META_W +: META_W]   = mem_meta[ridx];
  end

  always_ff @(posedge clk) begin
    if (push)
      for (int i = 0; i < SLOTS; i++)
        mem_meta[wr_ptr + AW'(i)] <= in_meta[i*META_W +: META_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_vld   <= '0;
      mem_col   <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill      <= '0;
      avail     <= '0;
      acc       <= '0;
      waitc     <= '0;
      gen_color <= 1'b0;
      started   <= 1'b0;
    end else begin
      if (push) begin
        for (int i = 0; i < SLOTS; i++) begin
          mem_vld[wr_ptr + AW'(i)] <= in_slot_vld[i];
          mem_col[wr_ptr + AW'(i)] <= gen_color;
        end
        wr_ptr  <= wr_ptr + AW'(SLOTS);
        started <= 1'b1;
      end
      rd_ptr <= rd_ptr + AW'(rd_n);
      fill   <= fill + push_n - rd_n;
      avail  <= avail + (conf_eff ? waitc : '0) - rd_n;
      if (flip) begin
        gen_color <= ~gen_color;
        waitc     <= acc + push_n;
        acc       <= '0;
      end else begin
        acc <= acc + push_n;
      end
    end
  end
endmodule

module cmpl_order_tracker_chk #(
  parameter int SLOTS  = 4,
  parameter int META_W = 8,
  parameter int DEPTH  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    conf_valid,
  input logic [SLOTS-1:0]        out_valid,
  input logic [SLOTS-1:0]        out_color,
  input logic [SLOTS*META_W-1:0] out_meta,
  input logic [SLOTS-1:0]        out_read,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  // R8
  valid_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_valid + 1'b1) & out_valid) == '0);
  // R9
  read_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (((out_read + 1'b1) & out_read) == '0) && ((out_read & ~out_valid) == '0));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (fill <= $past(fill)));
  // R5
  held_chk: assert property (@(posedge clk) disable iff (rst)
    !conf_valid |=> ($countones(out_valid) <= $past($countones(out_valid))));
  // R6
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid[0] && !out_read[0]) |=> ($stable(out_color[0]) && $stable(out_meta[META_W-1:0])));
endmodule

bind cmpl_order_tracker cmpl_order_tracker_chk #(.SLOTS(SLOTS), .META_W(META_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .conf_valid(conf_valid),
  .out_valid(out_valid), .out_color(out_color), .out_meta(out_meta), .out_read(out_read),
  .fill(fill));

// File: tb/tb_cmpl_order_tracker.sv
module tb_cmpl_order_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4, META_W = 8, DEPTH = 16;

  logic clk = 0, rst = 1;
  logic in_valid = 0, conf_valid = 0, conf_color = 0;
  logic in_ready;
  logic [SLOTS-1:0] in_slot_vld = '0, out_valid, out_slot_vld, out_color, out_read = '0;
  logic [SLOTS*META_W-1:0] in_meta = '0, out_meta;
  int errors = 0, checks = 0;
  bit finished = 0;

  cmpl_order_tracker #(.SLOTS(SLOTS), .META_W(META_W), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SLOTS*META_W-1:0] wmeta(int k);
    logic [SLOTS*META_W-1:0] m;
    for (int i = 0; i < SLOTS; i++) m[i*META_W +: META_W] = 8'(k*16 + i);
    return m;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
    in_valid = 0; conf_valid = 0; out_read = '0;
  endtask

  task automatic push(int k, logic [SLOTS-1:0] v);
    in_valid = 1; in_meta = wmeta(k); in_slot_vld = v;
  endtask

  task automatic t_reset();
    rst = 1; cyc(); cyc(); rst = 0; cyc();
    chk("R1 ready", 64'(in_ready), 64'd1);
    chk("R1 valid", 64'(out_valid), 64'd0);
  endtask

  task automatic t_early_conf();
    conf_valid = 1; conf_color = 1; cyc();
    chk("R10 early conf", 64'(out_valid), 64'd0);
  endtask

  task automatic t_held();
    push(1, 4'b1011); cyc();
    chk("R5 word1 held", 64'(out_valid), 64'd0);
    push(2, 4'b1111); cyc();
    chk("R5 word2 held", 64'(out_valid), 64'd0);
  endtask

  task automatic t_release_first();
    conf_valid = 1; conf_color = 0; cyc();
    chk("R5 released", 64'(out_valid), 64'hf);
    chk("R2 first color", 64'(out_color), 64'h0);
    chk("R4 slot valid", 64'(out_slot_vld), 64'hb);
    chk("R6 meta word1", 64'(out_meta), 64'(wmeta(1)));
    out_read = 4'b0011; cyc();
    chk("R8 prefix", 64'(out_valid), 64'h3);
    chk("R6 shifted head", 64'(out_meta[15:0]), 64'h1312);
    out_read = 4'b0011; cyc();
    chk("R5 word2 waits", 64'(out_valid), 64'd0);
  endtask

  task automatic t_fill();
    for (int k = 3; k <= 5; k++) begin push(k, 4'b1111); cyc(); end
    chk("R7 full", 64'(in_ready), 64'd0);
    push(9, 4'b1111); cyc();
    conf_valid = 1; conf_color = 1; cyc();
    chk("R2 second color", 64'(out_color), 64'hf);
    chk("R6 meta word2", 64'(out_meta), 64'(wmeta(2)));
    out_read = 4'b1111; cyc();
    chk("R7 ready again", 64'(in_ready), 64'd1);
    chk("R5 words3-5 wait", 64'(out_valid), 64'd0);
  endtask

  task automatic t_same_cycle();
    push(6, 4'b0101); conf_valid = 1; conf_color = 0; cyc();
    chk("R3 color after conf0", 64'(out_color), 64'h0);
    for (int k = 3; k <= 5; k++) begin
      chk("R6 order", 64'(out_meta), 64'(wmeta(k)));
      chk("R8 full prefix", 64'(out_valid), 64'hf);
      out_read = 4'b1111; cyc();
    end
    chk("R7 ignored word absent", 64'(out_valid), 64'd0);
    conf_valid = 1; conf_color = 1; cyc();
    chk("R10 word6 released", 64'(out_valid), 64'hf);
    chk("R3 color word6", 64'(out_color), 64'hf);
    chk("R4 word6", 64'({out_slot_vld, out_meta}), 64'({4'b0101, wmeta(6)}));
    out_read = 4'b1111; cyc();
    chk("R6 empty", 64'({in_ready, out_valid}), 64'h10);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_early_conf();
    t_held();
    t_release_first();
    t_fill();
    t_same_cycle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule